// File: doc/BRIEF.md
# Security Configuration Register Write Control

This block holds a machine-level security configuration register and decides, bit by bit, what a software write may change. Some bits follow the written data, some can only be set and never cleared, one can be frozen at zero by the lock state of the memory-protection entries, and some exist only when an optional feature strap is on. A write also produces a one-cycle request to flush the address-translation cache, but only when protection entries are implemented.

The CSR access path presents a write strobe and data after it has done its own privilege checks. The protection unit supplies its per-entry lock bits, sampled in the same cycle as the write. The feature straps are steady configuration inputs. The register value is visible on the cycle after the write.

Top module: `secfg_wctl`

## Requirements
- R1: When the entry count parameter is 0, bits 0, 1 and 2 stay 0 through any write and the flush output never rises.
- R2: On a write with entries present, bit 2 (lock bypass) takes data bit 2. The exception is a write where any implemented entry's lock bit is 1 while bit 2 currently reads 0: then bit 2 stays 0.
- R3: Bit 0 (machine lockdown) and bit 1 (machine whitelist) are sticky. With entries present, each becomes its old value ORed with the written bit, so a write never clears them.
- R4: With entries present, each write cycle raises the flush output for exactly the following cycle. The flush output is 0 in every cycle after a cycle with no write.
- R5: Bits 4 (user seed access) and 5 (supervisor seed access) take data bits 4 and 5 on a write while the entropy strap is 1. Otherwise they hold their value.
- R6: Bit 3 (landing-pad enable) takes data bit 3 on a write while the control-flow strap is 1. Otherwise it holds its value.
- R7: After reset the register reads 0. Bits 6 to 31 always read 0.
- R8: A written value is visible on the cycle after the write strobe. Without a strobe the register does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | CSR write strobe |
| wr_data_i | input | 32 | CSR write data |
| lock_i | input | LOCK_W | Per-entry lock bits (width 1 when there are no entries) |
| entropy_en_i | input | 1 | Entropy-source feature strap |
| cfi_en_i | input | 1 | Control-flow-integrity feature strap |
| cfg_o | output | 32 | Register value |
| flush_o | output | 1 | Translation-cache flush pulse |

## Verification
The hardest state to reach is a frozen bypass bit. It needs a lock bit raised while the bypass bit already reads 0, and a later attempt to set it. The same holds for the contrasting case, where the bypass bit was already 1 before the lock appeared and must remain writable. Each sweep step therefore resets the register, presets every combination of the three policy bits with all locks clear, and then writes every data pattern under several lock patterns and all four strap combinations. A second instance built with no entries receives the same stimulus.

// File: rtl/secfg_pkg.sv
// Package: field positions and masks of the security configuration register.
// Assumes a 32-bit register; only bits 0..5 are implemented.
package secfg_pkg;
    localparam int CFG_W     = 32;
    localparam int BIT_LKDN  = 0;   // sticky machine lockdown
    localparam int BIT_WLST  = 1;   // sticky machine whitelist
    localparam int BIT_BYP   = 2;   // lock bypass
    localparam int BIT_LPAD  = 3;   // landing-pad enable
    localparam int BIT_USEED = 4;   // user seed access
    localparam int BIT_SSEED = 5;   // supervisor seed access

    typedef logic [CFG_W-1:0] cfg_t;

    // One-hot mask for a field position
    function automatic cfg_t bit_mask(input int idx);
        cfg_t m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

    localparam cfg_t STICKY_MASK = bit_mask(BIT_LKDN) | bit_mask(BIT_WLST);
    localparam cfg_t POLICY_MASK = STICKY_MASK | bit_mask(BIT_BYP);
    localparam cfg_t SEED_MASK   = bit_mask(BIT_USEED) | bit_mask(BIT_SSEED);
    localparam cfg_t LPAD_MASK   = bit_mask(BIT_LPAD);
    localparam cfg_t IMPL_MASK   = POLICY_MASK | SEED_MASK | LPAD_MASK;
endpackage

// File: rtl/secfg_lock_any.sv
// Module: reduces the per-entry lock bits to a single "some entry locked" flag.
// Assumes disabled entries still report their lock bit; with no entries the
// flag is forced low.
module secfg_lock_any #(
    parameter int ENTRIES = 8,
    localparam int LOCK_W = (ENTRIES == 0) ? 1 : ENTRIES
) (
    input  logic [LOCK_W-1:0] lock_i,
    output logic              any_locked_o
);
    localparam bit HAS_ENTRIES = (ENTRIES != 0);

    logic [LOCK_W:0] chain;

    assign chain[0] = 1'b0;

    // OR chain across the entries
    for (genvar i = 0; i < LOCK_W; i++) begin : g_or
        assign chain[i+1] = chain[i] | lock_i[i];
    end

    // Gate with the presence of entries
    assign any_locked_o = HAS_ENTRIES & chain[LOCK_W];
endmodule

// File: rtl/secfg_update.sv
// Module: computes the value the register takes on a write from the current
// value, the data, the lock flag and the feature straps.
// Assumes the caller only loads the result when the write strobe is high.
module secfg_update
    import secfg_pkg::*;
#(
    parameter bit HAS_ENTRIES = 1'b1
) (
    input  cfg_t cur_i,
    input  cfg_t data_i,
    input  logic any_locked_i,
    input  logic entropy_en_i,
    input  logic cfi_en_i,
    output cfg_t nxt_o
);
    logic bypass_frozen;
    cfg_t load_mask;
    cfg_t set_mask;

    // Bypass is frozen when a lock exists and bypass already reads 0
    assign bypass_frozen = any_locked_i & ~cur_i[BIT_BYP];

    // Fields replaced by data on this write
    always_comb begin
        load_mask = '0;
        if (HAS_ENTRIES && !bypass_frozen) load_mask |= bit_mask(BIT_BYP);
        if (entropy_en_i)                  load_mask |= SEED_MASK;
        if (cfi_en_i)                      load_mask |= LPAD_MASK;
    end

    // Fields that may only be set
    assign set_mask = HAS_ENTRIES ? STICKY_MASK : '0;

    // Merge and drop unimplemented bits
    assign nxt_o = ((cur_i & ~load_mask) | (data_i & load_mask) | (data_i & set_mask))
                   & IMPL_MASK;
endmodule

// File: rtl/secfg_wctl.sv
// Module: security configuration register with per-field write control and a
// translation-cache flush pulse. Assumes privilege checks are done upstream
// and that lock bits are valid in the write cycle.
module secfg_wctl
    import secfg_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int LOCK_W = (ENTRIES == 0) ? 1 : ENTRIES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [CFG_W-1:0]  wr_data_i,
    input  logic [LOCK_W-1:0] lock_i,
    input  logic              entropy_en_i,
    input  logic              cfi_en_i,
    output logic [CFG_W-1:0]  cfg_o,
    output logic              flush_o
);
    localparam bit HAS_ENTRIES = (ENTRIES != 0);

    logic any_locked;
    cfg_t cfg_q;
    cfg_t cfg_d;
    logic flush_q;

    secfg_lock_any #(.ENTRIES(ENTRIES)) u_lock (
        .lock_i       (lock_i),
        .any_locked_o (any_locked)
    );

    secfg_update #(.HAS_ENTRIES(HAS_ENTRIES)) u_upd (
        .cur_i        (cfg_q),
        .data_i       (wr_data_i),
        .any_locked_i (any_locked),
        .entropy_en_i (entropy_en_i),
        .cfi_en_i     (cfi_en_i),
        .nxt_o        (cfg_d)
    );

    // Register load and flush pulse generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            flush_q <= 1'b0;
        end else begin
            if (wr_en_i) cfg_q <= cfg_d;
            flush_q <= wr_en_i & HAS_ENTRIES;
        end
    end

    assign cfg_o   = cfg_q;
    assign flush_o = flush_q;
endmodule

// File: rtl/secfg_wctl_chk.sv
// Checker: temporal properties of the register write rules, bound to secfg_wctl.
module secfg_wctl_chk
    import secfg_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int LOCK_W = (ENTRIES == 0) ? 1 : ENTRIES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [CFG_W-1:0]  wr_data_i,
    input logic [LOCK_W-1:0] lock_i,
    input logic              entropy_en_i,
    input logic              cfi_en_i,
    input logic [CFG_W-1:0]  cfg_o,
    input logic              flush_o
);
    localparam bit HAS_ENTRIES = (ENTRIES != 0);

    p_zero_entries_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_ENTRIES |-> ((cfg_o & POLICY_MASK) == '0 && !flush_o));

    p_bypass_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (|lock_i) && !cfg_o[BIT_BYP]) |=> !cfg_o[BIT_BYP]);

    p_bypass_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_ENTRIES && wr_en_i && (!(|lock_i) || cfg_o[BIT_BYP]))
        |=> (cfg_o[BIT_BYP] == $past(wr_data_i[BIT_BYP])));

    p_lkdn_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[BIT_LKDN] |=> cfg_o[BIT_LKDN]);

    p_wlst_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[BIT_WLST] |=> cfg_o[BIT_WLST]);

    p_sticky_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_ENTRIES && wr_en_i && wr_data_i[BIT_WLST]) |=> cfg_o[BIT_WLST]);

    p_flush_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_ENTRIES && wr_en_i) |=> flush_o);

    p_flush_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> !flush_o);

    p_seed_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i || !entropy_en_i) |=> $stable(cfg_o[BIT_SSEED:BIT_USEED]));

    p_seed_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && entropy_en_i)
        |=> (cfg_o[BIT_SSEED:BIT_USEED] == $past(wr_data_i[BIT_SSEED:BIT_USEED])));

    p_lpad_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i || !cfi_en_i) |=> $stable(cfg_o[BIT_LPAD]));

    p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o & ~IMPL_MASK) == '0);

    p_no_write_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(cfg_o));
endmodule

bind secfg_wctl secfg_wctl_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .lock_i       (lock_i),
    .entropy_en_i (entropy_en_i),
    .cfi_en_i     (cfi_en_i),
    .cfg_o        (cfg_o),
    .flush_o      (flush_o)
);

// File: tb/tb_secfg_wctl.sv
// Bench: sweeps straps, lock patterns, preset policy bits and all low data
// patterns on a 4-entry instance and a 0-entry instance, against a model.
module tb_secfg_wctl;
    localparam int ENT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  lock = '0;
    logic        ent_en = 1'b0;
    logic        cfi_en = 1'b0;
    logic [31:0] cfg, cfg_z;
    logic        flush, flush_z;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m, mz;

    always #5 clk = ~clk;

    secfg_wctl #(.ENTRIES(ENT)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .lock_i(lock), .entropy_en_i(ent_en), .cfi_en_i(cfi_en),
        .cfg_o(cfg), .flush_o(flush)
    );

    secfg_wctl #(.ENTRIES(0)) dut_z (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .lock_i(lock[0:0]), .entropy_en_i(ent_en), .cfi_en_i(cfi_en),
        .cfg_o(cfg_z), .flush_o(flush_z)
    );

    // Reference: field rules written from the requirements
    function automatic logic [31:0] ref_next(input logic [31:0] old, input logic [31:0] d,
                                             input logic [3:0] lk, input bit has,
                                             input bit en_e, input bit en_c);
        logic [31:0] n;
        n = old;
        if (has) begin
            if (!((lk != 0) && !old[2])) n[2] = d[2];
            n[0] = old[0] | d[0];
            n[1] = old[1] | d[1];
        end
        if (en_e) begin n[4] = d[4]; n[5] = d[5]; end
        if (en_c) n[3] = d[3];
        return n & 32'h3F;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m = '0;
        mz = '0;
    endtask

    task automatic do_write(input logic [31:0] d, input logic [3:0] lk);
        @(negedge clk);
        chk("R4 idle flush", {31'b0, flush}, 32'b0);
        chk("R1 idle flush zero-entry", {31'b0, flush_z}, 32'b0);
        chk("R8 no-write hold", cfg, m);
        wr_en = 1'b1;
        wr_data = d;
        lock = lk;
        m  = ref_next(m, d, lk, 1'b1, ent_en, cfi_en);
        mz = ref_next(mz, d, lk, 1'b0, ent_en, cfi_en);
        @(negedge clk);
        wr_en = 1'b0;
        lock = '0;
        chk("R2 R3 R5 R6 R7 value", cfg, m);
        chk("R4 flush pulse", {31'b0, flush}, 32'b1);
        chk("R1 zero-entry value", cfg_z, mz);
        chk("R1 zero-entry flush", {31'b0, flush_z}, 32'b0);
    endtask

    function automatic logic [3:0] lock_pat(input int k);
        case (k)
            0: return 4'h0;
            1: return 4'h1;
            2: return 4'h2;
            3: return 4'h8;
            default: return 4'hF;
        endcase
    endfunction

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Main sweep
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset value", cfg, 32'h0);
        chk("R7 reset flush", {31'b0, flush}, 32'h0);
        for (int f = 0; f < 4; f++) begin
            ent_en = f[0];
            cfi_en = f[1];
            for (int li = 0; li < 5; li++) begin
                for (int p = 0; p < 8; p++) begin
                    for (int d = 0; d < 64; d++) begin
                        do_reset();
                        if (d == 0) chk("R7 reset value", cfg, 32'h0);
                        do_write(32'(p), 4'h0);
                        do_write(((d % 2 == 1) ? 32'hA5A5_A5C0 : 32'h5A5A_5A40) | 32'(d),
                                 lock_pat(li));
                    end
                end
            end
        end
        // R2: bypass already 1 stays writable under locks, frozen once cleared
        do_reset();
        do_write(32'h4, 4'h0);
        do_write(32'h0, 4'hF);
        do_write(32'h4, 4'h1);
        chk("R2 frozen after clear", {31'b0, cfg[2]}, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule